// File: doc/BRIEF.md
# MDIO Management Master

This block is a register-mapped master for the MII management interface. It reads and writes PHY registers by shifting a serial frame out on a management clock and data line that it drives itself. Software sets the clock divisor and the preamble option in a control register. For a write it loads the data register first. It then writes a command word that carries the operation, the PHY address and the register number. It polls the status register until the busy flag drops. After a read, the data register holds the 16 bits returned by the PHY.

Each frame is sent most significant bit first. It starts with 32 preamble ones, unless software has suppressed them. Then come the start pattern 01, the opcode (10 read, 01 write), the 5-bit PHY address, the 5-bit register number, two turnaround bits and 16 data bits. The management clock runs at the system clock divided by a programmable divisor. Output bits change when the clock falls, and input bits are captured when it rises. During the turnaround and data bits of a read, the block releases the data line. A self-clearing soft reset stops any frame in progress.

Top module: `mdio_master`

## Requirements
- R1: After reset, every register reads 0, the status busy bit is 0, and `mdc` and `mdioOe` are low.
- R2: A write to the command register (select 1) starts a frame when bit 15 (read) or bit 14 (write) is set. Bits [9:5] give the PHY address and bits [4:0] the register number. Busy (status bit 0, select 3) reads 1 from the cycle after that write. A command with neither bit set is ignored.
- R3: A command written while busy is ignored. The frame in flight completes unchanged, and the command register keeps the accepted address fields.
- R4: A write frame drives, in order: 32 ones, 01, 01, PHY address, register number, 10, then the data register (select 2) bits 15..0. `mdioOe` is high throughout. The line changes only at the start of a bit period.
- R5: A read frame drives 32 ones, 01, 10, PHY address and register number, then releases `mdioOe` for the last 18 bits. `mdioIn` is sampled at each rising `mdc`. The last 16 samples are placed in the data register when busy clears.
- R6: Control bit 8 (select 0) suppresses the preamble, which leaves a 32-bit frame.
- R7: Control bits [9+DIVW-1:9] hold the divisor minus one. One `mdc` period lasts D system clocks, with `mdc` high for floor(D/2) of them. A field of 0 is treated as D = 2.
- R8: Busy stays high for exactly (frame bits × D) cycles.
- R9: Writing 1 to control bit 0 starts a soft reset. Bit 0 reads 1 for one cycle. The reset then aborts any frame and clears the control fields and the data register, so busy, `mdc` and `mdioOe` go low.
- R10: A command with both bits 15 and 14 set runs as a read.
- R11: While not busy, `mdc` and `mdioOe` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regSel | input | 2 | Register select: 0 control, 1 command, 2 data, 3 status |
| regWr | input | 1 | Register write strobe |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Read data of the selected register |
| mdc | output | 1 | Management clock |
| mdioOut | output | 1 | Management data output |
| mdioOe | output | 1 | Management data output enable |
| mdioIn | input | 1 | Management data input |

## Verification
The assertions check on every cycle the following:
- busy follows an accepted command;
- the divider count stays inside the latched period;
- `mdc` and the output enable stay low when idle;
- the data line holds steady between bit boundaries;
- a command arriving mid-frame leaves the latched address alone;
- a soft reset empties the engine.

Only the bench scenarios show the serial content of each frame, the placement of the read data, the exact busy length, and the `mdc` period and duty for odd and even divisors. The same applies to preamble suppression and to the read priority when both command bits are set. The bench shows these through a PHY model that records every bit driven at a rising `mdc` and answers reads.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int PRE_LEN    = 32;
  localparam int FRAME_LEN  = 32;
  localparam int TOTAL_LEN  = PRE_LEN + FRAME_LEN;
  localparam int BITS_W     = $clog2(TOTAL_LEN + 1);
  localparam int CMD_RD_BIT = 15;
  localparam int CMD_WR_BIT = 14;
  localparam int CTRL_SUP   = 8;
  localparam int CTRL_DIV   = 9;
  localparam int CTRL_RST   = 0;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_CMD  = 2'd1,
    SEL_DATA = 2'd2,
    SEL_STAT = 2'd3
  } regSel_t;

  typedef struct packed {
    logic load;
    logic shift;
    logic sample;
    logic finish;
  } mdioStrobe_t;
endpackage

// File: rtl/mdio_seq.sv
module mdio_seq
  import mdio_pkg::*;
#(
  parameter int DIVW = 7
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            startReq,
  input  logic            softRst,
  input  logic [DIVW-1:0] divField,
  input  logic            suppress,
  output mdioStrobe_t     strobe,
  output logic            busy,
  output logic            mdc
);
  localparam int CW = DIVW + 1;

  logic [CW-1:0]     divLat;
  logic [CW-1:0]     cnt;
  logic [CW-1:0]     lowLen;
  logic [CW-1:0]     effDiv;
  logic [BITS_W-1:0] bitsLeft;
  logic              running;
  logic              mdcQ;
  logic              lastTick;

  assign effDiv   = (divField == '0) ? CW'(2) : ({1'b0, divField} + CW'(1));
  assign lowLen   = divLat - (divLat >> 1);
  assign lastTick = running && (cnt == divLat - CW'(1));

  always_comb begin
    strobe.load   = startReq && !running && !softRst;
    strobe.sample = running && (cnt == lowLen - CW'(1));
    strobe.shift  = lastTick && (bitsLeft != BITS_W'(1));
    strobe.finish = lastTick && (bitsLeft == BITS_W'(1));
  end

  always_ff @(posedge clk) begin
    if (!rstN || softRst) begin
      running  <= 1'b0;
      cnt      <= '0;
      mdcQ     <= 1'b0;
      bitsLeft <= '0;
      divLat   <= CW'(2);
    end else if (strobe.load) begin
      running  <= 1'b1;
      cnt      <= '0;
      mdcQ     <= 1'b0;
      divLat   <= effDiv;
      bitsLeft <= suppress ? BITS_W'(FRAME_LEN) : BITS_W'(TOTAL_LEN);
    end else if (running) begin
      if (lastTick) begin
        cnt      <= '0;
        mdcQ     <= 1'b0;
        bitsLeft <= bitsLeft - BITS_W'(1);
        if (bitsLeft == BITS_W'(1)) running <= 1'b0;
      end else begin
        cnt <= cnt + CW'(1);
        if (strobe.sample) mdcQ <= 1'b1;
      end
    end
  end

  assign busy = running;
  assign mdc  = mdcQ;

  a_r2_busy_follows_start: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> busy);
  a_r7_count_in_period: assert property (@(posedge clk) disable iff (!rstN)
    running |-> (cnt < divLat));
  a_r11_mdc_idle_low: assert property (@(posedge clk) disable iff (!rstN)
    !running |-> !mdcQ);
endmodule

// File: rtl/mdio_dp.sv
module mdio_dp
  import mdio_pkg::*;
#(
  parameter int DIVW = 7
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [1:0]      regSel,
  input  logic            regWr,
  input  logic [31:0]     regWrData,
  output logic [31:0]     regRdData,
  input  mdioStrobe_t     strobe,
  input  logic            busy,
  input  logic            mdioIn,
  output logic            mdioOut,
  output logic            mdioOe,
  output logic            startReq,
  output logic            softRst,
  output logic [DIVW-1:0] divField,
  output logic            suppress
);
  logic [DIVW-1:0]      ctrlDiv;
  logic                 ctrlSup;
  logic                 rstPend;
  logic [4:0]           cmdPhy;
  logic [4:0]           cmdReg;
  logic                 cmdIsRead;
  logic [15:0]          dataReg;
  logic [15:0]          capture;
  logic [TOTAL_LEN-1:0] shiftOut;
  logic [TOTAL_LEN-1:0] shiftOe;
  logic                 cmdWrite;
  logic                 goRd;
  logic                 goWr;
  logic [FRAME_LEN-1:0] frameBits;
  logic [FRAME_LEN-1:0] frameOe;
  logic                 unusedWrBits;

  assign cmdWrite = regWr && (regSel == SEL_CMD);
  assign goRd     = regWrData[CMD_RD_BIT];
  assign goWr     = regWrData[CMD_WR_BIT];
  assign startReq = cmdWrite && (goRd || goWr) && !busy && !rstPend;
  assign softRst  = rstPend;
  assign divField = ctrlDiv;
  assign suppress = ctrlSup;
  assign unusedWrBits = ^regWrData;

  assign frameBits = {2'b01, (goRd ? 2'b10 : 2'b01), regWrData[9:5], regWrData[4:0],
                      (goRd ? 2'b00 : 2'b10), (goRd ? 16'h0000 : dataReg)};
  assign frameOe   = goRd ? {{14{1'b1}}, 18'b0} : {FRAME_LEN{1'b1}};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlDiv <= '0;
      ctrlSup <= 1'b0;
      rstPend <= 1'b0;
    end else if (regWr && (regSel == SEL_CTRL)) begin
      if (regWrData[CTRL_RST]) begin
        rstPend <= 1'b1;
        ctrlDiv <= '0;
        ctrlSup <= 1'b0;
      end else begin
        rstPend <= 1'b0;
        ctrlDiv <= regWrData[CTRL_DIV +: DIVW];
        ctrlSup <= regWrData[CTRL_SUP];
      end
    end else begin
      rstPend <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || rstPend) begin
      cmdPhy    <= '0;
      cmdReg    <= '0;
      cmdIsRead <= 1'b0;
      shiftOut  <= '0;
      shiftOe   <= '0;
      capture   <= '0;
      dataReg   <= '0;
    end else begin
      if (strobe.load) begin
        cmdPhy    <= regWrData[9:5];
        cmdReg    <= regWrData[4:0];
        cmdIsRead <= goRd;
        shiftOut  <= ctrlSup ? {frameBits, {PRE_LEN{1'b0}}} : {{PRE_LEN{1'b1}}, frameBits};
        shiftOe   <= ctrlSup ? {frameOe, {PRE_LEN{1'b0}}} : {{PRE_LEN{1'b1}}, frameOe};
      end else if (strobe.finish) begin
        shiftOut <= '0;
        shiftOe  <= '0;
      end else if (strobe.shift) begin
        shiftOut <= shiftOut << 1;
        shiftOe  <= shiftOe << 1;
      end
      if (strobe.sample) capture <= {capture[14:0], mdioIn};
      if (strobe.finish && cmdIsRead) dataReg <= capture;
      else if (regWr && (regSel == SEL_DATA)) dataReg <= regWrData[15:0];
    end
  end

  assign mdioOe  = shiftOe[TOTAL_LEN-1];
  assign mdioOut = shiftOe[TOTAL_LEN-1] & shiftOut[TOTAL_LEN-1];

  always_comb begin
    regRdData = '0;
    case (regSel)
      SEL_CTRL: begin
        regRdData[CTRL_DIV +: DIVW] = ctrlDiv;
        regRdData[CTRL_SUP]         = ctrlSup;
        regRdData[CTRL_RST]         = rstPend;
      end
      SEL_CMD:  regRdData[9:0]  = {cmdPhy, cmdReg};
      SEL_DATA: regRdData[15:0] = dataReg;
      default:  regRdData[0]    = busy;
    endcase
  end

  a_r3_busy_cmd_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (busy && cmdWrite && !rstPend) |=> ($stable(cmdPhy) && $stable(cmdReg) && $stable(cmdIsRead)));
  a_r4_line_steady: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !strobe.shift && !strobe.finish && !rstPend) |=> ($stable(mdioOut) && $stable(mdioOe)));
  a_r9_soft_reset_empties: assert property (@(posedge clk) disable iff (!rstN)
    rstPend |=> (!busy && (dataReg == 16'h0000) && !mdioOe));
  a_r11_oe_idle_low: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !mdioOe);
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int DIVW = 7
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  regSel,
  input  logic        regWr,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  output logic        mdc,
  output logic        mdioOut,
  output logic        mdioOe,
  input  logic        mdioIn
);
  mdioStrobe_t     strobe;
  logic            busy;
  logic            startReq;
  logic            softRst;
  logic [DIVW-1:0] divField;
  logic            suppress;

  mdio_seq #(.DIVW(DIVW)) seqInst (
    .clk(clk), .rstN(rstN), .startReq(startReq), .softRst(softRst),
    .divField(divField), .suppress(suppress), .strobe(strobe),
    .busy(busy), .mdc(mdc)
  );

  mdio_dp #(.DIVW(DIVW)) dpInst (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWr(regWr),
    .regWrData(regWrData), .regRdData(regRdData), .strobe(strobe),
    .busy(busy), .mdioIn(mdioIn), .mdioOut(mdioOut), .mdioOe(mdioOe),
    .startReq(startReq), .softRst(softRst), .divField(divField),
    .suppress(suppress)
  );
endmodule

// File: tb/mdio_master_test.sv
module mdio_master_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  regSel = 2'd0;
  logic        regWr = 1'b0;
  logic [31:0] regWrData = 32'h0;
  logic [31:0] regRdData;
  logic        mdc, mdioOut, mdioOe;
  logic        mdioIn = 1'b1;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  mdio_master uut (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWr(regWr),
    .regWrData(regWrData), .regRdData(regRdData), .mdc(mdc),
    .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioIn)
  );

  typedef struct packed {
    logic [1:0]  go;
    logic [4:0]  phy;
    logic [4:0]  rg;
    logic [15:0] val;
    logic        sup;
    logic [6:0]  divF;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{2'b01, 5'h01, 5'h00, 16'h1234, 1'b0, 7'd1},
    '{2'b10, 5'h1F, 5'h02, 16'hA5C3, 1'b0, 7'd2},
    '{2'b01, 5'h10, 5'h1F, 16'h8001, 1'b1, 7'd3},
    '{2'b10, 5'h0A, 5'h15, 16'h7FFE, 1'b1, 7'd1},
    '{2'b10, 5'h05, 5'h0C, 16'hFFFF, 1'b0, 7'd0},
    '{2'b11, 5'h13, 5'h09, 16'h5A0F, 1'b1, 7'd4}
  };

  // PHY model state
  int          riseCnt = 0;
  int          fallCnt = 0;
  int          drvCnt = 0;
  int          highCnt = 0;
  int          frameLen = 64;
  logic        respOn = 1'b0;
  logic [15:0] resp = 16'h0;
  logic [63:0] drvBits = 64'h0;
  logic        mdcPrev = 1'b0;

  always @(negedge clk) begin
    if (mdc && !mdcPrev) begin
      if (mdioOe) begin
        drvBits = {drvBits[62:0], mdioOut};
        drvCnt++;
      end
      riseCnt++;
    end
    if (!mdc && mdcPrev) begin
      fallCnt++;
      if (respOn && fallCnt >= frameLen - 16 && fallCnt < frameLen)
        mdioIn = resp[15 - (fallCnt - (frameLen - 16))];
      else if (respOn && fallCnt == frameLen - 17)
        mdioIn = 1'b0;
      else
        mdioIn = 1'b1;
    end
    if (mdc && riseCnt == 1) highCnt++;
    mdcPrev = mdc;
  end

  task automatic modelClear();
    riseCnt = 0; fallCnt = 0; drvCnt = 0; highCnt = 0;
    drvBits = 64'h0; mdioIn = 1'b1;
  endtask

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wrReg(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    regSel = sel; regWrData = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0; regWrData = 32'h0;
  endtask

  task automatic rdReg(input logic [1:0] sel, output logic [31:0] d);
    regSel = sel;
    #0.5;
    d = regRdData;
  endtask

  task automatic waitIdle(output int cyc);
    cyc = 0;
    regSel = 2'd3;
    #0.5;
    while (regRdData[0] && cyc < 20000) begin
      cyc++;
      @(negedge clk);
      #0.5;
    end
  endtask

  task automatic runVec(input vec_t v, input int idx);
    int d, n, cyc, expCnt;
    logic isRd;
    logic [13:0] head;
    logic [63:0] expBits;
    logic [31:0] rd;
    d = (v.divF == 7'd0) ? 2 : int'(v.divF) + 1;
    n = v.sup ? 32 : 64;
    isRd = v.go[1];
    head = {2'b01, (isRd ? 2'b10 : 2'b01), v.phy, v.rg};
    wrReg(2'd0, (32'(v.divF) << 9) | (32'(v.sup) << 8));
    if (!isRd) wrReg(2'd2, {16'h0, v.val});
    modelClear();
    frameLen = n; respOn = isRd; resp = v.val;
    wrReg(2'd1, {16'h0, v.go, 4'h0, v.phy, v.rg});
    waitIdle(cyc);
    if (isRd) begin
      expCnt = n - 18;
      expBits = v.sup ? {50'h0, head} : {18'h0, 32'hFFFF_FFFF, head};
    end else begin
      expCnt = n;
      expBits = v.sup ? {32'h0, head, 2'b10, v.val} : {32'hFFFF_FFFF, head, 2'b10, v.val};
    end
    $display("vector %0d", idx);
    check("R8 busy cycles", 64'(cyc), 64'(n * d));
    check("R7 mdc rises", 64'(riseCnt), 64'(n));
    check("R7 mdc high length", 64'(highCnt), 64'(d / 2));
    check(isRd ? "R5 driven bit count" : "R4 driven bit count", 64'(drvCnt), 64'(expCnt));
    check(v.sup ? "R6 frame bits" : (isRd ? "R5 frame bits" : "R4 frame bits"), drvBits, expBits);
    if (isRd) begin
      rdReg(2'd2, rd);
      check(v.go == 2'b11 ? "R10 read data" : "R5 read data", 64'(rd), 64'(v.val));
    end
    check("R11 idle lines", {62'h0, mdc, mdioOe}, 64'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int cyc;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int s = 0; s < 4; s++) begin
      rdReg(2'(s), rd);
      check("R1 register after reset", 64'(rd), 64'h0);
    end
    check("R1 lines after reset", {62'h0, mdc, mdioOe}, 64'h0);

    // R2 command without go bits is ignored
    wrReg(2'd1, 32'h0000_0021);
    rdReg(2'd3, rd);
    check("R2 no go bits stays idle", 64'(rd), 64'h0);
    repeat (3) @(negedge clk);
    rdReg(2'd3, rd);
    check("R2 no go bits still idle", 64'(rd), 64'h0);

    // R2 busy visible the cycle after the command write
    wrReg(2'd0, 32'h0000_0300);
    modelClear(); respOn = 1'b0; frameLen = 32;
    wrReg(2'd1, {16'h0, 2'b01, 4'h0, 5'h03, 5'h04});
    rdReg(2'd3, rd);
    check("R2 busy after command", 64'(rd), 64'h1);

    // R3 command while busy ignored
    repeat (4) @(negedge clk);
    wrReg(2'd1, {16'h0, 2'b10, 4'h0, 5'h09, 5'h07});
    rdReg(2'd1, rd);
    check("R3 command fields held", 64'(rd[9:0]), 64'({5'h03, 5'h04}));
    waitIdle(cyc);
    check("R3 first frame all driven", 64'(drvCnt), 64'd32);
    repeat (4) @(negedge clk);
    rdReg(2'd3, rd);
    check("R3 no second frame", 64'(rd), 64'h0);

    // table-driven frames
    for (int i = 0; i < NVEC; i++) runVec(VECS[i], i);

    // R9 soft reset mid-frame
    wrReg(2'd2, 32'h0000_BEEF);
    wrReg(2'd0, 32'h0000_0A00);
    modelClear(); respOn = 1'b1; frameLen = 64; resp = 16'h1111;
    wrReg(2'd1, {16'h0, 2'b10, 4'h0, 5'h02, 5'h01});
    repeat (20) @(negedge clk);
    wrReg(2'd0, 32'h0000_0A01);
    rdReg(2'd0, rd);
    check("R9 reset bit reads one", 64'(rd[0]), 64'h1);
    @(negedge clk);
    rdReg(2'd0, rd);
    check("R9 control cleared", 64'(rd), 64'h0);
    rdReg(2'd3, rd);
    check("R9 busy cleared", 64'(rd), 64'h0);
    rdReg(2'd2, rd);
    check("R9 data cleared", 64'(rd), 64'h0);
    check("R9 lines low", {62'h0, mdc, mdioOe}, 64'h0);
    repeat (30) @(negedge clk);
    check("R11 lines stay low", {62'h0, mdc, mdioOe}, 64'h0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule